// File: doc/BRIEF.md
# Display Channel Controller with Underrun Interrupt

This block is the control and status front end for a compositor that feeds three display output channels. Software programs each channel through a control register that holds enable, flush and one-shot bits and the active width and height. Each channel then runs a small sequencer. It leaves the off state when enabled and waits for a vertical-start pulse. It composites until the frame ends, and then either goes back to waiting or, in one-shot mode, halts after that single frame. One-shot mode is intended for a channel that feeds a memory writeback path.

The pixel datapath and the output FIFOs are outside the block. Each FIFO appears only as its full and empty levels and a read strobe from the pixel consumer. A read while the FIFO is empty during compositing is an underrun. An underrun sets a sticky per-channel flag in a global status word, and software clears that flag by writing one to its bit. The global control word carries a block enable and one interrupt enable per channel. The single interrupt line is the registered OR of every flag whose enable is set.

Top module: `disp_chan_ctrl`

## Requirements
- R1: A channel with its enable bit (control bit 0) set leaves the off state one cycle after the write and reports mode 1 (waiting). It reports mode 2 (compositing) and raises its `composing` output only in the cycle after a `vstart` pulse, and never before one.
- R2: In normal mode (control bit 2 clear), a `frame_end` pulse while compositing returns the channel to mode 1.
- R3: In one-shot mode (control bit 2 set), a `frame_end` pulse while compositing moves the channel to mode 3 (halted). The channel stays there whatever `vstart` does, until its enable is cleared.
- R4: Writing control bit 1 (flush) forces the channel to mode 0 (off) at the next edge. The bit reads back as 1 for one cycle and then as 0. In mode 0 the status word reads FIFO empty (bit 2) as 1 and FIFO full (bit 3) as 0, whatever the FIFO inputs are. In any other mode those two bits follow the inputs.
- R5: The underrun flag of channel c (global status bit c) sets in the cycle after `fifo_rd[c]` and `fifo_empty[c]` are both high in mode 2, and stays set. A read from an empty FIFO in any other mode leaves the flag clear.
- R6: Writing the global status word clears each flag whose bit is written as one, and writing zero changes nothing. If an underrun and a clearing write fall in the same cycle, the flag stays set.
- R7: `irq` is high in the cycle after any flag whose interrupt enable is set. The enable of channel c is global control bit c+1. A flag whose enable is clear never raises `irq`.
- R8: While the block enable (global control bit 0) is clear, every channel is held in mode 0. When it is set again, every enabled channel that is not flushing restarts by waiting for `vstart`.
- R9: The register map is: global control at address 0, global status at 1, the control word of channel c at 2+2c, and its status at 3+2c. Width sits at control bits 15:4 and height at bits 27:16, and both read back as written. The mode sits in status bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| vstart | input | NCH | Vertical-start pulse per channel |
| frame_end | input | NCH | End-of-frame pulse per channel |
| fifo_rd | input | NCH | Pixel consumer read strobe per FIFO |
| fifo_empty | input | NCH | FIFO empty level per channel |
| fifo_full | input | NCH | FIFO full level per channel |
| composing | output | NCH | Channel is in the compositing state |
| irq | output | 1 | Underrun interrupt |

## Verification
An underrun and a software write that clears the same flag can occur in the same cycle. The bench provokes this by holding `fifo_rd` high on an empty FIFO of a compositing channel during the same cycle as a write of one to that flag's status bit. It judges the result by reading the status word afterwards and expecting the flag still set. It also keeps apart the cycle in which a flag changes and the later cycle in which `irq` follows it, on both the rising and the falling side.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int REG_W   = 32;
    localparam int DIM_W   = 12;
    localparam int WID_LSB = 4;
    localparam int HGT_LSB = WID_LSB + DIM_W;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_DRAW = 2'd2,
        CH_HALT = 2'd3
    } ch_mode_e;

    typedef struct packed {
        logic [DIM_W-1:0] hgt;
        logic [DIM_W-1:0] wid;
        logic             one;
        logic             flush;
        logic             en;
    } ch_ctrl_t;

    function automatic ch_ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ch_ctrl_t c;
        c.en    = w[0];
        c.flush = w[1];
        c.one   = w[2];
        c.wid   = w[WID_LSB +: DIM_W];
        c.hgt   = w[HGT_LSB +: DIM_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ch_ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.flush;
        w[2] = c.one;
        w[WID_LSB +: DIM_W] = c.wid;
        w[HGT_LSB +: DIM_W] = c.hgt;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_stat(input ch_mode_e m,
                                                   input logic empty,
                                                   input logic full);
        logic [REG_W-1:0] w;
        w = '0;
        w[1:0] = m;
        w[2]   = empty;
        w[3]   = full;
        return w;
    endfunction

endpackage

// File: rtl/dcc_chan.sv
module dcc_chan
    import dcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_en,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] ctrl_wd,
    input  logic             vstart,
    input  logic             frame_end,
    input  logic             fifo_rd,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [REG_W-1:0] stat_rd,
    output logic             drawing,
    output logic             underrun_evt
);

    ch_ctrl_t ctrl_q;
    ch_mode_e mode_q, mode_d;
    logic     unused_bits;

    assign unused_bits = ^{ctrl_wd[3], ctrl_wd[REG_W-1:HGT_LSB+DIM_W]};

    // Control word; the flush bit is a one-cycle request.
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= unpack_ctrl(ctrl_wd);
        else
            ctrl_q.flush <= 1'b0;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CH_OFF:  if (ctrl_q.en) mode_d = CH_WAIT;
            CH_WAIT: if (vstart) mode_d = CH_DRAW;
            CH_DRAW: if (frame_end) mode_d = ctrl_q.one ? CH_HALT : CH_WAIT;
            default: mode_d = CH_HALT;
        endcase
        if (!blk_en || !ctrl_q.en || ctrl_q.flush)
            mode_d = CH_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= CH_OFF;
        else
            mode_q <= mode_d;
    end

    assign drawing      = (mode_q == CH_DRAW);
    assign underrun_evt = drawing && fifo_rd && fifo_empty;
    assign ctrl_rd      = pack_ctrl(ctrl_q);
    assign stat_rd      = pack_stat(mode_q,
                                    (mode_q == CH_OFF) || fifo_empty,
                                    (mode_q != CH_OFF) && fifo_full);

    assert_flush_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.flush && !ctrl_we |=> !ctrl_q.flush);

    assert_flush_stops_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.flush |=> mode_q == CH_OFF);

    assert_wait_needs_vstart_R1: assert property (@(posedge clk) disable iff (rst)
        mode_q != CH_DRAW && !vstart |=> mode_q != CH_DRAW);

    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        mode_q == CH_HALT |=> mode_q == CH_HALT || mode_q == CH_OFF);

    assert_blk_off_R8: assert property (@(posedge clk) disable iff (rst)
        !blk_en |=> mode_q == CH_OFF);

endmodule

// File: rtl/dcc_irq.sv
module dcc_irq #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] ie,
    output logic [NCH-1:0] flag_q,
    output logic           irq_q
);

    logic [NCH-1:0] clr_bits;

    assign clr_bits = clr_we ? clr_mask : '0;

    // A new underrun outranks a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr_bits) | evt;
            irq_q  <= |(flag_q & ie);
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
                flag_q[c] && !clr_bits[c] |=> flag_q[c]);
            assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
                evt[c] |=> flag_q[c]);
        end
    endgenerate

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_q & ie) == '0 |=> !irq_q);

endmodule

// File: rtl/disp_chan_ctrl.sv
module disp_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NCH-1:0]    vstart,
    input  logic [NCH-1:0]    frame_end,
    input  logic [NCH-1:0]    fifo_rd,
    input  logic [NCH-1:0]    fifo_empty,
    input  logic [NCH-1:0]    fifo_full,
    output logic [NCH-1:0]    composing,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_GST  = ADDR_W'(1);
    localparam int                CH_BASE = 2;

    logic           blk_en_q;
    logic [NCH-1:0] ie_q;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] evt;
    logic           gctl_we, gst_we;
    logic [REG_W-1:0] ctrl_rd [NCH];
    logic [REG_W-1:0] stat_rd [NCH];

    assign gctl_we = wr_en && (wr_addr == A_GCTL);
    assign gst_we  = wr_en && (wr_addr == A_GST);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_en_q <= 1'b0;
            ie_q     <= '0;
        end else if (gctl_we) begin
            blk_en_q <= wr_data[0];
            ie_q     <= wr_data[NCH:1];
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dcc_chan u_chan (
                .clk          (clk),
                .rst          (rst),
                .blk_en       (blk_en_q),
                .ctrl_we      (wr_en && (wr_addr == ADDR_W'(CH_BASE + 2*c))),
                .ctrl_wd      (wr_data),
                .vstart       (vstart[c]),
                .frame_end    (frame_end[c]),
                .fifo_rd      (fifo_rd[c]),
                .fifo_empty   (fifo_empty[c]),
                .fifo_full    (fifo_full[c]),
                .ctrl_rd      (ctrl_rd[c]),
                .stat_rd      (stat_rd[c]),
                .drawing      (composing[c]),
                .underrun_evt (evt[c])
            );
        end
    endgenerate

    dcc_irq #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_we   (gst_we),
        .clr_mask (wr_data[NCH-1:0]),
        .ie       (ie_q),
        .flag_q   (flag_q),
        .irq_q    (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_GCTL)
            rd_data = REG_W'({ie_q, blk_en_q});
        else if (rd_addr == A_GST)
            rd_data = REG_W'(flag_q);
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == ADDR_W'(CH_BASE + 2*c))
                rd_data = ctrl_rd[c];
            if (rd_addr == ADDR_W'(CH_BASE + 2*c + 1))
                rd_data = stat_rd[c];
        end
    end

    assert_underrun_only_drawing_R5: assert property (@(posedge clk) disable iff (rst)
        (evt & ~composing) == '0);

endmodule

// File: tb/disp_chan_ctrl_test.sv
module disp_chan_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] vstart = '0, frame_end = '0, fifo_rd = '0;
    logic [NCH-1:0] fifo_empty = '0, fifo_full = 3'b001;
    logic [NCH-1:0] composing;
    logic           irq;

    disp_chan_ctrl #(.NCH(NCH), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vstart(vstart), .frame_end(frame_end),
        .fifo_rd(fifo_rd), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .composing(composing), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   mask;
        logic [31:0]   exp;
        string         tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [AW-1:0] ct(int c); return AW'(2 + 2*c); endfunction
    function automatic logic [AW-1:0] st(int c); return AW'(3 + 2*c); endfunction

    task automatic tally(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected register values and compares them with the read port.
    initial begin
        forever begin
            rd_item_t it;
            wait (sb_q.size() != 0);
            it = sb_q[0];
            rd_addr = it.addr;
            #1;
            tally((rd_data & it.mask) == it.exp, it.tag, rd_data & it.mask, it.exp);
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_reg(input logic [AW-1:0] a, input logic [31:0] m,
                              input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.mask = m; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    localparam logic [31:0] CT0 = 32'h1 | (32'd640 << 4) | (32'd480 << 16);

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_reg(0, 32'hFFFF_FFFF, 32'h0, "R9 global control after reset");
        expect_reg(st(0), 32'hF, 32'h4, "R4 off status forces empty, hides full");
        tally(irq == 1'b0, "R7 irq low after reset", 32'(irq), 32'h0);

        wr(0, 32'h3);
        wr(ct(0), CT0);
        tick(1);
        expect_reg(ct(0), 32'hFFFF_FFFF, CT0, "R9 width/height readback");
        expect_reg(st(0), 32'hF, 32'h9, "R1 waiting with full reported");
        tick(3);
        expect_reg(st(0), 32'h3, 32'h1, "R1 still waiting without vstart");
        tally(composing == 3'b000, "R1 not composing before vstart", 32'(composing), 32'h0);
        vstart[0] = 1'b1; tick(1); vstart[0] = 1'b0;
        expect_reg(st(0), 32'hF, 32'hA, "R1 compositing after vstart");
        tally(composing == 3'b001, "R1 composing output", 32'(composing), 32'h1);

        fifo_full[0] = 1'b0;
        fifo_empty[0] = 1'b1; fifo_rd[0] = 1'b1; tick(1); fifo_rd[0] = 1'b0;
        expect_reg(1, 32'h7, 32'h1, "R5 underrun flag set");
        tally(irq == 1'b0, "R7 irq lags flag", 32'(irq), 32'h0);
        tick(1);
        tally(irq == 1'b1, "R7 irq raised", 32'(irq), 32'h1);
        tick(3);
        expect_reg(1, 32'h7, 32'h1, "R5 flag sticky");
        wr(1, 32'h0);
        expect_reg(1, 32'h7, 32'h1, "R6 writing zero keeps flag");
        wr(1, 32'h1);
        expect_reg(1, 32'h7, 32'h0, "R6 write one clears flag");
        tally(irq == 1'b1, "R7 irq falls one cycle late", 32'(irq), 32'h1);
        tick(1);
        tally(irq == 1'b0, "R7 irq low after clear", 32'(irq), 32'h0);

        fifo_rd[0] = 1'b1;
        wr(1, 32'h1);
        fifo_rd[0] = 1'b0;
        expect_reg(1, 32'h7, 32'h1, "R6 underrun wins over same-cycle clear");
        wr(1, 32'h1);
        expect_reg(1, 32'h7, 32'h0, "R6 cleared after coincidence");

        wr(0, 32'h1);
        fifo_rd[0] = 1'b1; tick(1); fifo_rd[0] = 1'b0;
        tick(2);
        expect_reg(1, 32'h7, 32'h1, "R5 flag set while masked");
        tally(irq == 1'b0, "R7 masked flag keeps irq low", 32'(irq), 32'h0);
        wr(1, 32'h1);
        wr(0, 32'h3);

        frame_end[0] = 1'b1; tick(1); frame_end[0] = 1'b0;
        expect_reg(st(0), 32'hF, 32'h5, "R2 back to waiting after frame end");
        fifo_rd[0] = 1'b1; tick(1); fifo_rd[0] = 1'b0;
        tick(1);
        expect_reg(1, 32'h7, 32'h0, "R5 no flag while waiting");
        tally(irq == 1'b0, "R5 no irq while waiting", 32'(irq), 32'h0);

        wr(ct(1), 32'h5);
        tick(1);
        expect_reg(st(1), 32'h3, 32'h1, "R3 one-shot channel waiting");
        vstart[1] = 1'b1; tick(1); vstart[1] = 1'b0;
        expect_reg(st(1), 32'h3, 32'h2, "R3 one-shot compositing");
        frame_end[1] = 1'b1; tick(1); frame_end[1] = 1'b0;
        expect_reg(st(1), 32'h3, 32'h3, "R3 halted after one frame");
        vstart[1] = 1'b1; tick(1); vstart[1] = 1'b0;
        tick(1);
        expect_reg(st(1), 32'h3, 32'h3, "R3 vstart ignored when halted");
        tally(composing[1] == 1'b0, "R3 not composing when halted", 32'(composing[1]), 32'h0);

        wr(ct(0), CT0 | 32'h2);
        expect_reg(ct(0), 32'h2, 32'h2, "R4 flush bit visible");
        tick(1);
        expect_reg(ct(0), 32'h2, 32'h0, "R4 flush bit self-clears");
        expect_reg(st(0), 32'h3, 32'h0, "R4 flush forces off");
        fifo_full[0] = 1'b1; fifo_empty[0] = 1'b0;
        wr(ct(0), CT0 & ~32'h1);
        tick(1);
        expect_reg(st(0), 32'hF, 32'h4, "R4 disabled: off, empty set, full clear");

        wr(0, 32'h0);
        tick(1);
        expect_reg(st(1), 32'h3, 32'h0, "R8 block disable forces channel off");
        wr(ct(2), 32'h1);
        tick(2);
        expect_reg(st(2), 32'h3, 32'h0, "R8 channel held off while block disabled");
        wr(0, 32'h1);
        tick(1);
        expect_reg(st(1), 32'h3, 32'h1, "R8 channel 1 restarts waiting");
        expect_reg(st(2), 32'h3, 32'h1, "R8 channel 2 restarts waiting");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule